// File: doc/BRIEF.md
# LCD Common Scan Timing Generator

This block produces the row-scan timing for a multiplexed dot-matrix LCD driver. It runs from the display oscillator clock. It steps through the common electrodes one slot at a time. For each slot it shows the selected common as a one-hot vector and the active row as a binary index. A one-clock strobe tells the segment path to load the data for the new row. The block also supplies the drive polarity used for AC inversion and a flag that picks the bias ratio for the analog divider.

The scan has three multiplex ratios. Eight commons suit a single line of short font, eleven suit a single line of tall font, and sixteen suit two lines. The slot is 800 clocks long at the two single-line ratios and 400 clocks long at the two-line ratio, so a frame lasts 6400, 8800 or 6400 clocks. A requested ratio takes effect only when the current frame finishes. Polarity can flip once per frame or once per row slot. A mirroring input starts the scan at the upper half of the commons and tells the segment path to reverse its column order.

All control inputs are plain level signals. The outputs have no handshake; each slot simply lasts its fixed number of clocks.

Top module: `lcd_scan_timing`

## Requirements
- R1: After reset the outputs show row 0, with latch_stb high, polarity low and bias_fifth low. The active ratio after reset is eight commons.
- R2: At the 8-common and 11-common ratios every row slot lasts exactly 800 clocks. At the 16-common ratio it lasts exactly 400 clocks.
- R3: latch_stb is high for exactly one clock, the first clock of each slot. row_idx takes its new value in that same clock and holds it for the rest of the slot.
- R4: row_idx counts 0 up to N-1 and then returns to 0. N is 8 for duty_code 2'b00, 11 for duty_code 2'b01 and 16 for duty_code 2'b10 or 2'b11.
- R5: With wave_per_line low, polarity flips only at the first clock of each new frame.
- R6: With wave_per_line high, polarity flips at the first clock of every row slot.
- R7: bias_fifth is high exactly when the active ratio is 16 commons.
- R8: A change on duty_code has no effect until the current frame finishes. The new ratio then starts at row 0 with a fresh slot.
- R9: com_sel is one-hot. With orient_normal high its set bit is row_idx. With orient_normal low its set bit is (row_idx + 8) mod 16, so the scan begins at bit 8.
- R10: seg_reversed is the inverse of orient_normal. Both seg_reversed and com_sel follow orient_normal in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| duty_code | input | 2 | Requested ratio: 00 = 8, 01 = 11, 1x = 16 commons |
| orient_normal | input | 1 | 1 = natural common order, 0 = mirrored |
| wave_per_line | input | 1 | 1 = flip polarity per slot, 0 = per frame |
| com_sel | output | 16 | One-hot selected common electrode |
| row_idx | output | 4 | Logical row of the current slot |
| latch_stb | output | 1 | One-clock pulse at the start of each slot |
| polarity | output | 1 | AC inversion phase |
| bias_fifth | output | 1 | 1 = one-fifth bias, 0 = one-quarter bias |
| seg_reversed | output | 1 | 1 = segment columns run in reverse order |

## Verification
The embedded properties are checked on every cycle. They cover the following:
- com_sel is one-hot.
- The strobe is a single-clock pulse, and row_idx changes only while it is high.
- row_idx steps by one and wraps at frame end.
- The active ratio and the bias flag move only at frame boundaries.
- Polarity holds or flips as the selected scheme demands.

Exact slot and frame lengths for each ratio need the bench's directed scenarios, which sample at counted cycles. The same holds for the deferral of a ratio request to the next frame, for the mirrored bit positions and for the immediate effect of the orientation input.

// File: rtl/lcd_scan_pkg.sv
package lcd_scan_pkg;

  typedef enum logic [1:0] {
    DUTY_EIGHTH    = 2'b00,
    DUTY_ELEVENTH  = 2'b01,
    DUTY_SIXTEENTH = 2'b10
  } duty_e;

  // Codes 2'b10 and 2'b11 both select the sixteen-common ratio.
  function automatic duty_e decode_duty(input logic [1:0] code);
    case (code)
      2'b00:   return DUTY_EIGHTH;
      2'b01:   return DUTY_ELEVENTH;
      default: return DUTY_SIXTEENTH;
    endcase
  endfunction

endpackage

// File: rtl/scan_slot_timer.sv
module scan_slot_timer #(
  parameter int SLOT_LONG  = 800,
  parameter int SLOT_SHORT = 400
) (
  input  logic clk,
  input  logic rst_n,
  input  logic short_slot,
  output logic slot_start,
  output logic slot_end
);
  localparam int CW = $clog2(SLOT_LONG);
  localparam logic [CW-1:0] LONG_LAST  = CW'(SLOT_LONG - 1);
  localparam logic [CW-1:0] SHORT_LAST = CW'(SLOT_SHORT - 1);

  logic [CW-1:0] cnt;

  assign slot_end   = (cnt == (short_slot ? SHORT_LAST : LONG_LAST));
  assign slot_start = (cnt == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        cnt <= '0;
    else if (slot_end) cnt <= '0;
    else               cnt <= cnt + 1'b1;
  end

  AST_SLOT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= LONG_LAST); // R2
  AST_STB_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    slot_start |=> !slot_start); // R3
  AST_SLOT_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    slot_end |=> slot_start); // R3

endmodule

// File: rtl/scan_row_seq.sv
module scan_row_seq
  import lcd_scan_pkg::*;
#(
  parameter int NUM_COMMONS     = 16,
  parameter int ROWS_SMALL_FONT = 8,
  parameter int ROWS_LARGE_FONT = 11,
  localparam int RW = $clog2(NUM_COMMONS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          slot_end,
  input  logic [1:0]    duty_code,
  output logic [RW-1:0] row,
  output duty_e         active_duty,
  output logic          frame_end
);
  logic [RW-1:0] last_row;

  always_comb begin
    case (active_duty)
      DUTY_EIGHTH:   last_row = RW'(ROWS_SMALL_FONT - 1);
      DUTY_ELEVENTH: last_row = RW'(ROWS_LARGE_FONT - 1);
      default:       last_row = RW'(NUM_COMMONS - 1);
    endcase
  end

  assign frame_end = slot_end && (row == last_row);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      row         <= '0;
      active_duty <= DUTY_EIGHTH;
    end else if (frame_end) begin
      row         <= '0;
      active_duty <= decode_duty(duty_code);
    end else if (slot_end) begin
      row         <= row + 1'b1;
    end
  end

  AST_ROW_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !slot_end |=> $stable(row)); // R3
  AST_ROW_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (slot_end && !frame_end) |=> (row == $past(row) + 1'b1)); // R4
  AST_ROW_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    frame_end |=> (row == '0)); // R4
  AST_DUTY_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_end |=> $stable(active_duty)); // R8

endmodule

// File: rtl/scan_polarity.sv
module scan_polarity (
  input  logic clk,
  input  logic rst_n,
  input  logic per_line,
  input  logic slot_end,
  input  logic frame_end,
  output logic polarity
);
  logic flip;

  assign flip = per_line ? slot_end : frame_end;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    polarity <= 1'b0;
    else if (flip) polarity <= ~polarity;
  end

  AST_POL_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
    (!per_line && !frame_end) |=> $stable(polarity)); // R5
  AST_POL_LINE: assert property (@(posedge clk) disable iff (!rst_n)
    (per_line && slot_end) |=> (polarity != $past(polarity))); // R6

endmodule

// File: rtl/scan_com_decode.sv
module scan_com_decode #(
  parameter int NUM_COMMONS = 16,
  localparam int RW = $clog2(NUM_COMMONS)
) (
  input  logic [RW-1:0]          row,
  input  logic                   mirrored,
  output logic [NUM_COMMONS-1:0] com_sel
);
  localparam logic [RW:0] HALF_W = (RW+1)'(NUM_COMMONS / 2);
  localparam logic [RW:0] FULL_W = (RW+1)'(NUM_COMMONS);

  logic [RW:0]   shifted;
  logic [RW-1:0] phys;

  always_comb begin
    shifted = {1'b0, row} + (mirrored ? HALF_W : '0);
    if (shifted >= FULL_W) phys = RW'(shifted - FULL_W);
    else                   phys = RW'(shifted);
  end

  for (genvar i = 0; i < NUM_COMMONS; i++) begin : g_com
    assign com_sel[i] = (phys == RW'(i));
  end

endmodule

// File: rtl/lcd_scan_timing.sv
module lcd_scan_timing
  import lcd_scan_pkg::*;
#(
  parameter int NUM_COMMONS     = 16,
  parameter int ROWS_SMALL_FONT = 8,
  parameter int ROWS_LARGE_FONT = 11,
  parameter int SLOT_LONG       = 800,
  parameter int SLOT_SHORT      = 400,
  localparam int RW = $clog2(NUM_COMMONS)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [1:0]             duty_code,
  input  logic                   orient_normal,
  input  logic                   wave_per_line,
  output logic [NUM_COMMONS-1:0] com_sel,
  output logic [RW-1:0]          row_idx,
  output logic                   latch_stb,
  output logic                   polarity,
  output logic                   bias_fifth,
  output logic                   seg_reversed
);
  duty_e active_duty;
  logic  slot_end;
  logic  frame_end;

  scan_slot_timer #(
    .SLOT_LONG (SLOT_LONG),
    .SLOT_SHORT(SLOT_SHORT)
  ) u_timer (
    .clk       (clk),
    .rst_n     (rst_n),
    .short_slot(active_duty == DUTY_SIXTEENTH),
    .slot_start(latch_stb),
    .slot_end  (slot_end)
  );

  scan_row_seq #(
    .NUM_COMMONS    (NUM_COMMONS),
    .ROWS_SMALL_FONT(ROWS_SMALL_FONT),
    .ROWS_LARGE_FONT(ROWS_LARGE_FONT)
  ) u_rows (
    .clk        (clk),
    .rst_n      (rst_n),
    .slot_end   (slot_end),
    .duty_code  (duty_code),
    .row        (row_idx),
    .active_duty(active_duty),
    .frame_end  (frame_end)
  );

  scan_polarity u_pol (
    .clk      (clk),
    .rst_n    (rst_n),
    .per_line (wave_per_line),
    .slot_end (slot_end),
    .frame_end(frame_end),
    .polarity (polarity)
  );

  scan_com_decode #(
    .NUM_COMMONS(NUM_COMMONS)
  ) u_com (
    .row     (row_idx),
    .mirrored(~orient_normal),
    .com_sel (com_sel)
  );

  assign bias_fifth   = (active_duty == DUTY_SIXTEENTH);
  assign seg_reversed = ~orient_normal;

  AST_COM_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(com_sel) == 1); // R9
  AST_ROW_ON_STB: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(row_idx) |-> latch_stb); // R3
  AST_BIAS_AT_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(bias_fifth) |-> (latch_stb && row_idx == '0)); // R7

endmodule

// File: tb/test_lcd_scan_timing.sv
module test_lcd_scan_timing;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  duty_code = 2'b00;
  logic        orient_normal = 1'b1;
  logic        wave_per_line = 1'b0;
  logic [15:0] com_sel;
  logic [3:0]  row_idx;
  logic        latch_stb;
  logic        polarity;
  logic        bias_fifth;
  logic        seg_reversed;

  int tests = 0;
  int fails = 0;
  int t = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  lcd_scan_timing i_lcd_scan_timing (
    .clk          (clk),
    .rst_n        (rst_n),
    .duty_code    (duty_code),
    .orient_normal(orient_normal),
    .wave_per_line(wave_per_line),
    .com_sel      (com_sel),
    .row_idx      (row_idx),
    .latch_stb    (latch_stb),
    .polarity     (polarity),
    .bias_fifth   (bias_fifth),
    .seg_reversed (seg_reversed)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s at t=%0d: actual %0h expected %0h", req, what, t, act, exp);
    end
  endtask

  task automatic restart(input logic [1:0] d, input logic o, input logic w);
    @(negedge clk);
    rst_n = 1'b0;
    duty_code = d;
    orient_normal = o;
    wave_per_line = w;
    @(negedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    t = 0;
  endtask

  task automatic go_to(input int target);
    while (t < target) begin
      @(negedge clk);
      t++;
    end
  endtask

  task automatic run_reset_and_slots();
    restart(2'b00, 1'b1, 1'b0);
    chk("R1", "row", row_idx, 0);
    chk("R1", "com_sel", com_sel, 16'h0001);
    chk("R1", "latch_stb", latch_stb, 1);
    chk("R1", "polarity", polarity, 0);
    chk("R1", "bias_fifth", bias_fifth, 0);
    chk("R10", "seg_reversed", seg_reversed, 0);
    go_to(1);
    chk("R3", "stb drops", latch_stb, 0);
    go_to(799);
    chk("R2", "row held", row_idx, 0);
    chk("R3", "stb low mid-slot", latch_stb, 0);
    go_to(800);
    chk("R2", "row advance", row_idx, 1);
    chk("R3", "stb with new row", latch_stb, 1);
    chk("R9", "com_sel row1", com_sel, 16'h0002);
    go_to(801);
    chk("R3", "stb one clock", latch_stb, 0);
    go_to(6399);
    chk("R4", "last row", row_idx, 7);
    chk("R5", "pol before frame end", polarity, 0);
    go_to(6400);
    chk("R4", "wrap", row_idx, 0);
    chk("R5", "pol after frame", polarity, 1);
  endtask

  task automatic run_duty_switch();
    restart(2'b00, 1'b1, 1'b0);
    go_to(10);
    duty_code = 2'b10;
    go_to(6399);
    chk("R8", "old ratio row", row_idx, 7);
    chk("R7", "bias before switch", bias_fifth, 0);
    go_to(6400);
    chk("R8", "restart row", row_idx, 0);
    chk("R7", "bias after switch", bias_fifth, 1);
    go_to(6799);
    chk("R2", "short slot held", row_idx, 0);
    go_to(6800);
    chk("R2", "short slot advance", row_idx, 1);
    go_to(12799);
    chk("R4", "row 15", row_idx, 15);
    chk("R5", "pol mid frame", polarity, 1);
    go_to(12800);
    chk("R4", "wrap 16", row_idx, 0);
    chk("R5", "pol second frame", polarity, 0);
  endtask

  task automatic run_large_font();
    restart(2'b01, 1'b1, 1'b0);
    go_to(6400);
    chk("R8", "first frame at eight", row_idx, 0);
    go_to(14399);
    chk("R2", "row 9 long slot", row_idx, 9);
    go_to(14400);
    chk("R4", "row 10", row_idx, 10);
    chk("R9", "com_sel row10", com_sel, 16'h0400);
    chk("R7", "bias quarter", bias_fifth, 0);
    go_to(15200);
    chk("R4", "wrap 11", row_idx, 0);
  endtask

  task automatic run_line_inversion();
    restart(2'b00, 1'b1, 1'b1);
    go_to(799);
    chk("R6", "pol before slot end", polarity, 0);
    go_to(800);
    chk("R6", "pol slot1", polarity, 1);
    go_to(1600);
    chk("R6", "pol slot2", polarity, 0);
    go_to(6400);
    chk("R6", "pol after 8 slots", polarity, 0);
  endtask

  task automatic run_mirror();
    restart(2'b11, 1'b0, 1'b0);
    chk("R9", "mirror start", com_sel, 16'h0100);
    chk("R10", "seg reversed", seg_reversed, 1);
    go_to(800);
    chk("R9", "mirror row1", com_sel, 16'h0200);
    go_to(6400);
    chk("R7", "code 11 gives fifth", bias_fifth, 1);
    go_to(9600);
    chk("R4", "row 8", row_idx, 8);
    chk("R9", "mirror wrap to bit0", com_sel, 16'h0001);
    orient_normal = 1'b1;
    #1;
    chk("R10", "orient live com", com_sel, 16'h0100);
    chk("R10", "orient live seg", seg_reversed, 0);
  endtask

  initial begin
    run_reset_and_slots();
    run_duty_switch();
    run_large_font();
    run_line_inversion();
    run_mirror();
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      tests++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

endmodule